// File: doc/BRIEF.md
# Two-Bank Sensor Control Register File with Staged Handover

This block keeps two complete copies (bank 0 and bank 1) of the 16-bit control values that frame timing logic needs for a readout: integration time, line and frame length, window corners, skip increments, binning, analog and digital gains, operating mode and a pixel-combine bypass. Software writes either copy at any time through a plain write/read port, and a single select bit names the copy that should be in force.

The select bit does not act at once. It is taken up at frame-start strobes in two steps. On the first strobe after the bit changes, only the integration time follows the new bank. On the next strobe, all other values follow. Exposure is set up one frame ahead of readout, so this staging keeps every frame uniformly exposed under one parameter set. A switch back to the first bank uses the same two steps.

Top module: `ctx_switch_regs`

## Requirements
- R1: After reset both banks hold zero, the select bit is 0 (bank 0), both applied-bank flags are 0 and every applied value is zero.
- R2: The address is {bank bit, 5-bit index}, with the bank bit as the MSB. Index 0 is integration time and indices 1..19 are the other values, in the order line length, frame length, x start, x end, y start, y end, x odd inc, y odd inc, row bin, col bin, fine gain, coarse gain, red, green-red, green-blue, blue, global gain, op mode, combine bypass. Index 31 in either bank is the select bit (data bit 0). Read data appears on rdata_o one cycle after the address is presented.
- R3: A write to the select bit leaves int_bank_o, par_bank_o and every applied value unchanged until a frame_start_i pulse arrives.
- R4: On the first frame_start_i after the select bit changes, int_time_o and int_bank_o follow the new bank. params_o and par_bank_o keep the old bank.
- R5: On the second frame_start_i, params_o and par_bank_o follow the new bank as well.
- R6: A switch from bank 1 back to bank 0 follows the same two-strobe sequence.
- R7: When the select bit is written several times between two strobes, only the last value written before the strobe is taken up.
- R8: A write to the bank that is not applied to a value group leaves that group's applied outputs unchanged.
- R9: Read-back returns the stored content of the addressed bank, not the applied value.
- R10: A write to the bank currently applied to a value group is visible on the applied outputs right after the write's clock edge.
- R11: Writes to indices 20..30 are ignored, and reads from those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle strobe at each frame start |
| we_i | input | 1 | Write enable |
| addr_i | input | 6 | {bank bit, index} |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after address |
| int_time_o | output | 16 | Applied integration time |
| params_o | output | 304 | Applied values for indices 1..19, index i at bits [(i-1)*16 +: 16] |
| int_bank_o | output | 1 | Bank applied to integration time |
| par_bank_o | output | 1 | Bank applied to the other values |

## Verification
If a stage register is wrong, the fault appears on int_bank_o or par_bank_o at the first frame_start_i that advances it. It then shows on int_time_o or params_o in the same cycle, provided the two banks hold different contents. The bench therefore loads distinct values into both banks before it toggles the select bit. If a bank write goes to the wrong place, it appears either as a disturbed applied output right after the write edge or as a wrong read-back one cycle after the address.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned NUM_REGS = 20;
  localparam int unsigned SEL_IDX  = 31;
  localparam int unsigned IDX_INT  = 0;
  localparam int unsigned IDX_FRM  = 2;
endpackage

// File: rtl/ctx_bank.sv
module ctx_bank #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned NUM_REGS = 20,
  parameter bit          BANK_ID  = 1'b0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic                             bank_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (bank_i == BANK_ID) && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[g] <= '0;
      else if (hit) regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ctx_stage.sv
module ctx_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_we_i,
  input  logic sel_wdata_i,
  input  logic frame_start_i,
  output logic sel_o,
  output logic int_sel_o,
  output logic par_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o     <= 1'b0;
      int_sel_o <= 1'b0;
      par_sel_o <= 1'b0;
    end else begin
      if (sel_we_i) sel_o <= sel_wdata_i;
      // integration time leads the rest by one frame
      if (frame_start_i) begin
        int_sel_o <= sel_o;
        par_sel_o <= int_sel_o;
      end
    end
  end
endmodule

// File: rtl/ctx_apply.sv
module ctx_apply #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 20,
  localparam int unsigned NUM_PAR = NUM_REGS - 1
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank0_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank1_i,
  input  logic                            int_sel_i,
  input  logic                            par_sel_i,
  output logic [DATA_W-1:0]               int_time_o,
  output logic [NUM_PAR*DATA_W-1:0]       params_o
);
  assign int_time_o = int_sel_i ? bank1_i[0] : bank0_i[0];
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_par
    assign params_o[(g-1)*DATA_W +: DATA_W] = par_sel_i ? bank1_i[g] : bank0_i[g];
  end
endmodule

// File: rtl/ctx_switch_regs.sv
module ctx_switch_regs #(
  parameter int unsigned DATA_W   = ctx_pkg::DATA_W,
  parameter int unsigned IDX_W    = ctx_pkg::IDX_W,
  parameter int unsigned NUM_REGS = ctx_pkg::NUM_REGS,
  localparam int unsigned ADDR_W  = IDX_W + 1,
  localparam int unsigned NUM_PAR = NUM_REGS - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_start_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [DATA_W-1:0]         int_time_o,
  output logic [NUM_PAR*DATA_W-1:0] params_o,
  output logic                      int_bank_o,
  output logic                      par_bank_o
);
  localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(ctx_pkg::SEL_IDX);

  logic [1:0][NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic                                 bank_bit;
  logic [IDX_W-1:0]                     idx;
  logic                                 sel_q;
  logic                                 sel_we;
  logic [DATA_W-1:0]                    rd_next;

  assign bank_bit = addr_i[ADDR_W-1];
  assign idx      = addr_i[IDX_W-1:0];
  assign sel_we   = we_i && (idx == SEL_IDX);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ctx_bank #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .BANK_ID(b[0])
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_i),
      .bank_i (bank_bit),
      .idx_i  (idx),
      .wdata_i(wdata_i),
      .regs_o (bank_q[b])
    );
  end

  ctx_stage u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_we_i     (sel_we),
    .sel_wdata_i  (wdata_i[0]),
    .frame_start_i(frame_start_i),
    .sel_o        (sel_q),
    .int_sel_o    (int_bank_o),
    .par_sel_o    (par_bank_o)
  );

  ctx_apply #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_apply (
    .bank0_i   (bank_q[0]),
    .bank1_i   (bank_q[1]),
    .int_sel_i (int_bank_o),
    .par_sel_i (par_bank_o),
    .int_time_o(int_time_o),
    .params_o  (params_o)
  );

  always_comb begin
    rd_next = '0;
    if (idx == SEL_IDX) begin
      rd_next[0] = sel_q;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (idx == IDX_W'(i)) rd_next = bank_q[bank_bit][i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end
endmodule

// File: rtl/ctx_switch_sva.sv
module ctx_switch_sva #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned NUM_REGS = 20,
  localparam int unsigned ADDR_W  = IDX_W + 1,
  localparam int unsigned NUM_PAR = NUM_REGS - 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      frame_start_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         int_time_o,
  input logic [NUM_PAR*DATA_W-1:0] params_o,
  input logic                      int_bank_o,
  input logic                      par_bank_o,
  input logic                      sel_q
);
  assert_int_follows_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> int_bank_o == $past(sel_q));

  assert_par_follows_int_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> par_bank_o == $past(int_bank_o));

  assert_hold_between_frames_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(int_bank_o) && $stable(par_bank_o));

  assert_inactive_int_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !frame_start_i && (addr_i[ADDR_W-1] != int_bank_o) |=> $stable(int_time_o));

  assert_inactive_par_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !frame_start_i && (addr_i[ADDR_W-1] != par_bank_o) |=> $stable(params_o));

  assert_no_write_no_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !frame_start_i |=> $stable(int_time_o) && $stable(params_o));
endmodule

bind ctx_switch_regs ctx_switch_sva #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .int_time_o   (int_time_o),
  .params_o     (params_o),
  .int_bank_o   (int_bank_o),
  .par_bank_o   (par_bank_o),
  .sel_q        (sel_q)
);

// File: tb/tb_ctx_switch_regs.sv
module tb_ctx_switch_regs;
  localparam int DW = 16;
  localparam int NP = 19;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          we_i = 1'b0;
  logic [5:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o, int_time_o;
  logic [NP*DW-1:0] params_o;
  logic          int_bank_o, par_bank_o;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_req = 1'b0;
  logic          rd_pipe = 1'b0;

  always #5 clk = ~clk;

  ctx_switch_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .int_time_o(int_time_o), .params_o(params_o),
    .int_bank_o(int_bank_o), .par_bank_o(par_bank_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] par(input int idx);
    return params_o[(idx-1)*DW +: DW];
  endfunction

  task automatic wr(input logic bank, input int idx, input logic [DW-1:0] d);
    @(posedge clk); #1;
    we_i = 1'b1; addr_i = {bank, 5'(idx)}; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  // driver: push expected read data, monitor compares one cycle later
  task automatic rd(input string tag, input logic bank, input int idx, input logic [DW-1:0] exp);
    @(posedge clk); #1;
    addr_i = {bank, 5'(idx)};
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic fs();
    @(posedge clk); #1;
    frame_start_i = 1'b1;
    @(posedge clk); #1;
    frame_start_i = 1'b0;
  endtask

  always @(posedge clk) rd_pipe <= rd_req;

  always @(negedge clk) begin
    if (rd_pipe) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 read with empty scoreboard actual=%h expected=none", rdata_o);
      end else begin
        chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 int_time", int_time_o, 16'h0);
    chk("R1 int_bank", {15'b0, int_bank_o}, 16'h0);
    chk("R1 par_bank", {15'b0, par_bank_o}, 16'h0);
    chk("R1 frame len", par(2), 16'h0);
    rd("R1 select", 1'b0, 31, 16'h0);

    // R10 writes to the applied bank show at once
    wr(1'b0, 0, 16'h0100);
    chk("R10 int_time", int_time_o, 16'h0100);
    wr(1'b0, 2, 16'h0465);
    chk("R10 frame len", par(2), 16'h0465);
    // R8 inactive bank writes
    wr(1'b1, 0, 16'h0200);
    chk("R8 int_time", int_time_o, 16'h0100);
    wr(1'b1, 2, 16'h0500);
    wr(1'b1, 19, 16'hBEEF);
    chk("R8 frame len", par(2), 16'h0465);
    chk("R8 bypass", par(19), 16'h0000);
    // R9 R2 read-back of stored contents
    rd("R9 bank1 int", 1'b1, 0, 16'h0200);
    rd("R2 bank0 frame", 1'b0, 2, 16'h0465);
    rd("R9 bank1 bypass", 1'b1, 19, 16'hBEEF);
    // R11 unused index
    wr(1'b0, 25, 16'h1234);
    rd("R11 unused", 1'b0, 25, 16'h0000);
    chk("R11 int_time", int_time_o, 16'h0100);

    // R3 select write alone does nothing
    wr(1'b0, 31, 16'h0001);
    chk("R3 int_time", int_time_o, 16'h0100);
    chk("R3 int_bank", {15'b0, int_bank_o}, 16'h0);
    rd("R2 select", 1'b1, 31, 16'h0001);
    // R4 first strobe
    fs();
    chk("R4 int_time", int_time_o, 16'h0200);
    chk("R4 int_bank", {15'b0, int_bank_o}, 16'h1);
    chk("R4 frame len", par(2), 16'h0465);
    chk("R4 par_bank", {15'b0, par_bank_o}, 16'h0);
    wr(1'b0, 2, 16'h0777);
    chk("R10 frame len bank0", par(2), 16'h0777);
    wr(1'b1, 0, 16'h0201);
    chk("R10 int_time bank1", int_time_o, 16'h0201);
    wr(1'b0, 0, 16'h0111);
    chk("R8 int_time bank0", int_time_o, 16'h0201);
    // R5 second strobe
    fs();
    chk("R5 frame len", par(2), 16'h0500);
    chk("R5 bypass", par(19), 16'hBEEF);
    chk("R5 par_bank", {15'b0, par_bank_o}, 16'h1);
    rd("R9 applied vs stored", 1'b0, 2, 16'h0777);

    // R6 back to bank 0
    wr(1'b1, 31, 16'h0000);
    fs();
    chk("R6 int_time", int_time_o, 16'h0111);
    chk("R6 frame len", par(2), 16'h0500);
    fs();
    chk("R6 frame len", par(2), 16'h0777);
    chk("R6 par_bank", {15'b0, par_bank_o}, 16'h0);

    // R7 several toggles in one frame
    wr(1'b0, 31, 16'h0001);
    wr(1'b0, 31, 16'h0000);
    wr(1'b1, 31, 16'h0001);
    wr(1'b0, 31, 16'h0000);
    fs();
    chk("R7 int_time last=0", int_time_o, 16'h0111);
    chk("R7 int_bank last=0", {15'b0, int_bank_o}, 16'h0);
    wr(1'b0, 31, 16'h0000);
    wr(1'b0, 31, 16'h0001);
    fs();
    chk("R7 int_time last=1", int_time_o, 16'h0201);
    chk("R7 frame len", par(2), 16'h0777);
    fs();
    chk("R7 frame len", par(2), 16'h0500);

    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule